// File: doc/BRIEF.md
# Pipelined Store Write Issuer

This block turns a stream of cache store requests into Wishbone write strobes. A requester raises `st_valid_i` and keeps the address, data and byte selects steady until `st_done_o` pulses. The pulse comes in the cycle where that store's strobe is first driven on the bus, so the store is complete long before its acknowledge returns. The store is released even if the slave stalls that strobe.

An idle bus is opened by registering the first store. Later stores to the same 4 KiB page go straight onto the open cycle, one per cycle, when the slave is not stalling and fewer than the limit of writes are still waiting for acknowledge. A store to another page waits until every acknowledge has come back and `cyc` has gone low, and then it opens a fresh cycle. The acknowledge count rises on every accepted strobe and falls on every acknowledge. Both can happen in one cycle.

Top module: `st_issue`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it, `wb_cyc_o`, `wb_stb_o`, `st_done_o` and `st_busy_o` are 0.
- R2: `st_done_o` is 1 in exactly those cycles where `wb_stb_o` is 1 and the previous cycle did not have a stalled strobe. Each store that is requested produces exactly one done pulse.
- R3: If a strobe is stalled (`wb_stb_o`=1 and `wb_stall_i`=1), the next cycle still shows `wb_stb_o`=1 with the same address, data and select.
- R4: A store to the page already held by an open cycle (address bits above bit 11 are equal) is issued without `wb_cyc_o` dropping. A burst of same-page stores with no stall uses a single bus cycle.
- R5: A store that joins an already open cycle is only presented in a cycle where `wb_stall_i` is 0.
- R6: Accepted strobes minus acknowledges never exceeds 7. With no acknowledges returning, the eighth store of a burst is held back.
- R7: The first strobe of every bus cycle starts with no writes outstanding. A store whose page differs from the open cycle's page is only issued in a new cycle, after `wb_cyc_o` has been low for at least one cycle.
- R8: After a cycle where `wb_cyc_o` is 1, the outstanding count becomes 0, and no strobe is stalled, `wb_cyc_o` is 0. Otherwise an open `wb_cyc_o` stays 1.
- R9: Accepted strobes carry the requested address, data and select in request order, with `wb_we_o` and `wb_cyc_o` both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request pending; held until done |
| st_adr_i | input | ADR_W | Store byte address |
| st_dat_i | input | DAT_W | Store data |
| st_sel_i | input | DAT_W/8 | Byte selects |
| st_done_o | output | 1 | Store completed (strobe first shown) |
| st_busy_o | output | 1 | A bus cycle is open |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Strobe |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | ADR_W | Bus address |
| wb_dat_o | output | DAT_W | Bus write data |
| wb_sel_o | output | DAT_W/8 | Bus byte selects |
| wb_stall_i | input | 1 | Slave stall |
| wb_ack_i | input | 1 | Slave acknowledge |

## Verification
The first directed burst sends same-page stores with no stall and no acknowledge. It separates correct chaining, which gives a single cycle, from premature cycle closure, and it shows the cap taking effect at seven. An alternating-page sequence must open one new cycle per store, which separates page-change handling from chaining. The long random run mixes stalls, late acknowledges and page locality to exercise ordering, held strobes and same-cycle accept and acknowledge.

// File: rtl/st_issue_pkg.sv
package st_issue_pkg;
  localparam int unsigned ADR_W = 32;
  localparam int unsigned DAT_W = 64;
  localparam int unsigned SEL_W = DAT_W / 8;

  typedef struct packed {
    logic [ADR_W-1:0] adr;
    logic [DAT_W-1:0] dat;
    logic [SEL_W-1:0] sel;
  } st_beat_t;
endpackage

// File: rtl/st_pend_ctr.sv
module st_pend_ctr #(
  parameter int unsigned MAX_PEND = 7,
  localparam int unsigned CNT_W = $clog2(MAX_PEND + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             zero_nxt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i && !dec_i) cnt_d = cnt_q + 1'b1;
    else if (!inc_i && dec_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o      = cnt_q;
  assign full_o     = (cnt_q >= CNT_W'(MAX_PEND));
  assign zero_nxt_o = (cnt_d == '0);
endmodule

// File: rtl/st_page_cmp.sv
module st_page_cmp #(
  parameter int unsigned ADR_W  = 32,
  parameter int unsigned PAGE_W = 12,
  localparam int unsigned PN_W = ADR_W - PAGE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ADR_W-1:0] adr_i,
  output logic             hit_o
);
  logic [PN_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     page_q <= '0;
    else if (load_i) page_q <= adr_i[ADR_W-1:PAGE_W];
  end

  assign hit_o = (adr_i[ADR_W-1:PAGE_W] == page_q);
endmodule

// File: rtl/st_issue.sv
module st_issue
  import st_issue_pkg::*;
#(
  parameter int unsigned PAGE_W   = 12,
  parameter int unsigned MAX_PEND = 7,
  localparam int unsigned CNT_W = $clog2(MAX_PEND + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             st_valid_i,
  input  logic [ADR_W-1:0] st_adr_i,
  input  logic [DAT_W-1:0] st_dat_i,
  input  logic [SEL_W-1:0] st_sel_i,
  output logic             st_done_o,
  output logic             st_busy_o,
  output logic             wb_cyc_o,
  output logic             wb_stb_o,
  output logic             wb_we_o,
  output logic [ADR_W-1:0] wb_adr_o,
  output logic [DAT_W-1:0] wb_dat_o,
  output logic [SEL_W-1:0] wb_sel_o,
  input  logic             wb_stall_i,
  input  logic             wb_ack_i
);
  logic cyc_q, hold_vld_q, hold_first_q;
  st_beat_t hold_q, req_beat, out_beat;
  logic open_cyc, chain, accept, page_hit, full, zero_nxt;
  logic [CNT_W-1:0] pend_cnt;

  assign req_beat = '{adr: st_adr_i, dat: st_dat_i, sel: st_sel_i};

  // idle bus: register the store, strobe goes out next cycle
  assign open_cyc = !cyc_q && st_valid_i;
  // open cycle: same-page store goes straight through
  assign chain    = cyc_q && !hold_vld_q && st_valid_i && page_hit && !wb_stall_i && !full;
  assign wb_stb_o = hold_vld_q | chain;
  assign accept   = wb_stb_o && !wb_stall_i;
  assign out_beat = hold_vld_q ? hold_q : req_beat;

  st_pend_ctr #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (accept),
    .dec_i      (wb_ack_i),
    .cnt_o      (pend_cnt),
    .full_o     (full),
    .zero_nxt_o (zero_nxt)
  );

  st_page_cmp #(.ADR_W(ADR_W), .PAGE_W(PAGE_W)) u_page (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (open_cyc),
    .adr_i  (st_adr_i),
    .hit_o  (page_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q        <= 1'b0;
      hold_vld_q   <= 1'b0;
      hold_first_q <= 1'b0;
      hold_q       <= '0;
    end else if (open_cyc) begin
      cyc_q        <= 1'b1;
      hold_vld_q   <= 1'b1;
      hold_first_q <= 1'b1;
      hold_q       <= req_beat;
    end else begin
      hold_first_q <= 1'b0;
      if (hold_vld_q && !wb_stall_i) hold_vld_q <= 1'b0;
      if (cyc_q && zero_nxt && !(hold_vld_q && wb_stall_i) && !chain) cyc_q <= 1'b0;
    end
  end

  assign st_done_o = (hold_vld_q && hold_first_q) || chain;
  assign st_busy_o = cyc_q;
  assign wb_cyc_o  = cyc_q;
  assign wb_we_o   = cyc_q;
  assign wb_adr_o  = out_beat.adr;
  assign wb_dat_o  = out_beat.dat;
  assign wb_sel_o  = out_beat.sel;

  logic unused_cnt;
  assign unused_cnt = ^pend_cnt;
endmodule

// File: rtl/st_issue_chk.sv
module st_issue_chk #(
  parameter int unsigned ADR_W    = 32,
  parameter int unsigned DAT_W    = 64,
  parameter int unsigned MAX_PEND = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wb_cyc_o,
  input logic             wb_stb_o,
  input logic             wb_we_o,
  input logic [ADR_W-1:0] wb_adr_o,
  input logic [DAT_W-1:0] wb_dat_o,
  input logic             wb_stall_i,
  input logic             wb_ack_i,
  input logic             st_done_o
);
  int unsigned chk_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_cnt <= 0;
    else chk_cnt <= chk_cnt + ((wb_stb_o && !wb_stall_i) ? 1 : 0)
                            - ((wb_ack_i && chk_cnt != 0) ? 1 : 0);
  end

  a_r6_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_cnt <= MAX_PEND);
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_stb_o && wb_stall_i) |=> (wb_stb_o && $stable(wb_adr_o) && $stable(wb_dat_o)));
  a_r2_done_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_done_o |-> wb_stb_o);
  a_r9_stb_cyc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o |-> (wb_cyc_o && wb_we_o));
  a_r5_chain_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_done_o && wb_stall_i) |-> !$past(wb_cyc_o));
  a_r7_new_cyc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wb_cyc_o) |-> (chk_cnt == 0));
endmodule

bind st_issue st_issue_chk #(
  .ADR_W(st_issue_pkg::ADR_W), .DAT_W(st_issue_pkg::DAT_W), .MAX_PEND(MAX_PEND)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o),
  .wb_we_o(wb_we_o), .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o),
  .wb_stall_i(wb_stall_i), .wb_ack_i(wb_ack_i), .st_done_o(st_done_o)
);

// File: tb/sim_st_issue.sv
module sim_st_issue;
  import st_issue_pkg::*;
  localparam int MAXP = 7;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic             st_valid_i = 1'b0;
  logic [ADR_W-1:0] st_adr_i = '0;
  logic [DAT_W-1:0] st_dat_i = '0;
  logic [SEL_W-1:0] st_sel_i = '0;
  logic             wb_stall_i = 1'b0;
  logic             wb_ack_i = 1'b0;
  logic st_done_o, st_busy_o, wb_cyc_o, wb_stb_o, wb_we_o;
  logic [ADR_W-1:0] wb_adr_o;
  logic [DAT_W-1:0] wb_dat_o;
  logic [SEL_W-1:0] wb_sel_o;

  st_issue u0 (
    .clk_i(clk), .rst_ni(rst_ni), .st_valid_i(st_valid_i), .st_adr_i(st_adr_i),
    .st_dat_i(st_dat_i), .st_sel_i(st_sel_i), .st_done_o(st_done_o),
    .st_busy_o(st_busy_o), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o),
    .wb_we_o(wb_we_o), .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o),
    .wb_sel_o(wb_sel_o), .wb_stall_i(wb_stall_i), .wb_ack_i(wb_ack_i)
  );

  int n_chk = 0, n_fail = 0;
  logic [ADR_W-1:0] q_adr[$];
  logic [DAT_W-1:0] q_dat[$];
  logic [SEL_W-1:0] q_sel[$];

  int  stall_pct, ack_pct, req_pct, same_pct, gen_left;
  bit  ack_en, taken, prev_held, prev_cyc, exp_lo, exp_hi, abort;
  int  mon_cnt, max_cnt, n_new, n_chain, n_done, n_gen, wait_cyc;
  logic [ADR_W-1:0] prev_adr;
  logic [ADR_W-PAGE_BITS-1:0] cyc_page, last_page;
  localparam int PAGE_BITS = 12;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADR_W-PAGE_BITS-1:0] pick_page(input logic [ADR_W-PAGE_BITS-1:0] last, input int same);
    if ($urandom_range(99) < same) return last;
    return (last == 20'h40000) ? 20'h40001 : 20'h40000;
  endfunction

  task automatic new_req();
    logic [ADR_W-PAGE_BITS-1:0] pg;
    pg = pick_page(last_page, same_pct);
    last_page = pg;
    st_adr_i = {pg, 9'($urandom_range(511)), 3'b000};
    st_dat_i = {$urandom, $urandom};
    st_sel_i = SEL_W'($urandom_range(255) | 1);
    st_valid_i = 1'b1;
    q_adr.push_back(st_adr_i);
    q_dat.push_back(st_dat_i);
    q_sel.push_back(st_sel_i);
    gen_left--;
    n_gen++;
    wait_cyc = 0;
  endtask

  task automatic cycle();
    bit acc, first, exp_done;
    int nxt;
    @(negedge clk);
    wb_stall_i = ($urandom_range(99) < stall_pct);
    wb_ack_i = ack_en && mon_cnt > 0 && ($urandom_range(99) < ack_pct);
    if (taken) begin
      st_valid_i = 1'b0;
      taken = 1'b0;
    end
    if (!st_valid_i && gen_left > 0 && $urandom_range(99) < req_pct) new_req();
    #1;
    acc = wb_stb_o && !wb_stall_i;
    if (exp_lo) chk(!wb_cyc_o, "R8", "cyc after drain", wb_cyc_o, 0);
    if (exp_hi) chk(wb_cyc_o, "R8", "cyc held", wb_cyc_o, 1);
    exp_done = wb_stb_o && !prev_held;
    chk(st_done_o == exp_done, "R2", "done", st_done_o, exp_done);
    if (prev_held) chk(wb_stb_o && wb_adr_o == prev_adr, "R3", "held adr", wb_adr_o, prev_adr);
    first = wb_stb_o && !prev_held;
    if (first && prev_cyc) begin
      n_chain++;
      chk(!wb_stall_i, "R5", "chain under stall", wb_stall_i, 0);
      chk(wb_adr_o[ADR_W-1:PAGE_BITS] == cyc_page, "R4", "chain page", wb_adr_o[ADR_W-1:PAGE_BITS], cyc_page);
    end else if (first) begin
      n_new++;
      chk(mon_cnt == 0, "R7", "pending at new cycle", mon_cnt, 0);
      cyc_page = wb_adr_o[ADR_W-1:PAGE_BITS];
    end
    if (acc) begin
      chk(wb_cyc_o && wb_we_o, "R9", "cyc/we", {wb_cyc_o, wb_we_o}, 3);
      if (q_adr.size() == 0) chk(0, "R9", "unexpected write", wb_adr_o, 0);
      else begin
        chk(wb_adr_o == q_adr[0], "R9", "adr order", wb_adr_o, q_adr[0]);
        chk(wb_dat_o == q_dat[0], "R9", "dat", wb_dat_o, q_dat[0]);
        chk(wb_sel_o == q_sel[0], "R9", "sel", wb_sel_o, q_sel[0]);
        void'(q_adr.pop_front()); void'(q_dat.pop_front()); void'(q_sel.pop_front());
      end
    end
    nxt = mon_cnt + (acc ? 1 : 0) - (wb_ack_i ? 1 : 0);
    if (acc) chk(nxt <= MAXP, "R6", "outstanding", nxt, MAXP);
    if (nxt > max_cnt) max_cnt = nxt;
    exp_lo = wb_cyc_o && nxt == 0 && !(wb_stb_o && wb_stall_i);
    exp_hi = wb_cyc_o && !exp_lo;
    mon_cnt = nxt;
    prev_held = wb_stb_o && wb_stall_i;
    prev_cyc = wb_cyc_o;
    prev_adr = wb_adr_o;
    if (st_done_o) begin
      taken = 1'b1;
      n_done++;
    end
    if (st_valid_i && !taken) wait_cyc++;
  endtask

  task automatic run_idle(input int limit);
    for (int i = 0; i < limit; i++) begin
      cycle();
      if (wait_cyc > 2000) break;
      if (gen_left == 0 && !st_valid_i && q_adr.size() == 0 && mon_cnt == 0 && !wb_cyc_o) return;
    end
    chk(0, "R2", "watchdog", 0, 1);
    abort = 1'b1;
  endtask

  initial begin
    int d0, nn0;
    void'($urandom(32'h5eed_1234));
    last_page = 20'h40000;
    ack_en = 0; stall_pct = 0; ack_pct = 0; req_pct = 0; same_pct = 100; gen_left = 0;
    repeat (3) @(negedge clk);
    chk(!wb_cyc_o && !wb_stb_o && !st_done_o && !st_busy_o, "R1", "reset outputs",
        {wb_cyc_o, wb_stb_o, st_done_o, st_busy_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!wb_cyc_o && !wb_stb_o && !st_done_o && !st_busy_o, "R1", "after reset",
        {wb_cyc_o, wb_stb_o, st_done_o, st_busy_o}, 0);

    // cap: same page, no stall, no ack
    req_pct = 100; gen_left = 9;
    repeat (30) cycle();
    chk(mon_cnt == MAXP, "R6", "cap reached", mon_cnt, MAXP);
    chk(n_done == MAXP, "R6", "eighth held", n_done, MAXP);
    chk(st_valid_i && !taken, "R6", "eighth waiting", st_valid_i, 1);
    chk(n_new == 1, "R4", "single cycle", n_new, 1);
    chk(n_chain == MAXP - 1, "R4", "chained count", n_chain, MAXP - 1);
    ack_en = 1; ack_pct = 50;
    run_idle(2000);

    // page change every store
    if (!abort) begin
      nn0 = n_new; same_pct = 0; gen_left = 6; stall_pct = 20;
      run_idle(2000);
      chk(n_new - nn0 == 6, "R7", "new cycles on page change", n_new - nn0, 6);
    end

    // random mix
    if (!abort) begin
      d0 = n_done; same_pct = 80; stall_pct = 25; ack_pct = 40; req_pct = 70; gen_left = 400;
      run_idle(60000);
      chk(n_done - d0 == 400, "R2", "done per store", n_done - d0, 400);
    end
    chk(n_done == n_gen, "R2", "total done", n_done, n_gen);
    chk(q_adr.size() == 0, "R9", "all writes seen", q_adr.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule